// File: doc/BRIEF.md
# Per-Processor Device Interrupt Router

This block steers up to 64 device interrupt sources to four processors. Devices raise or withdraw a source through a post strobe or a clear strobe, each carrying a 6-bit source number. The block keeps one global vector of raw requests, and software gives each processor its own 64-bit enable mask. A processor's pending vector is the AND of its mask with the raw vector. That vector is held as state and is recomputed whenever a mask or the raw vector changes. Each processor gets one level interrupt line, which goes high when any of its pending bits is set.

Software uses a simple register port with valid, write, address, size and data. Only aligned 64-bit accesses are legal. The masks can be read and written. The pending vectors and the raw vector can only be read. An illegal access, or a write the block does not support, leaves all state as it was and sets a sticky error flag.

Top module: `irq_router`

## Requirements
- R1: For each processor c, the pending vector read at register index 4+c (byte offset 0x100 + 0x40*c) equals mask c AND the raw vector at all times.
- R2: A post strobe for source n sets bit n of the raw vector, which is read at register index 8 (byte offset 0x200).
- R3: A clear strobe for source n clears raw bit n and the matching pending bits. A clear for a source whose raw bit is already 0 changes no state and no output.
- R4: If a post and a clear arrive in the same cycle for the same source, the post wins and the bit ends set. If they name different sources, both take effect.
- R5: A legal write to register index c (byte offset 0x40*c, c in 0..3) replaces mask c as a whole. Reading the same register returns the new mask.
- R6: dev_irq[c] is the OR of pending vector c. It changes on the second rising edge after the cycle that carried the post, clear or mask write.
- R7: A read returns its data with rd_valid high one cycle after the request. The data is the state before that edge. An unmapped index reads as 0. A write never raises rd_valid.
- R8: An access is legal only if its size code is 3 (8 bytes) and address bits 5:0 are 0. Any other access sets err_flag, changes no mask, and a read of this kind returns 0.
- R9: A write to a pending register, the raw register or an unmapped index sets err_flag and changes no state.
- R10: err_flag stays set until reset.
- R11: If a mask write and a post arrive in the same cycle, the pending vector is computed from the new mask and the new raw vector.
- R12: After reset, all masks, the raw vector, the pending vectors, dev_irq, rd_valid and err_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_vld | input | 1 | Post strobe for one source |
| post_idx | input | 6 | Source number to post |
| clr_vld | input | 1 | Clear strobe for one source |
| clr_idx | input | 6 | Source number to clear |
| reg_vld | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset; register index is offset >> 6 |
| reg_size | input | 2 | log2 of the access size in bytes |
| reg_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| err_flag | output | 1 | Sticky error for illegal or unsupported accesses |
| dev_irq | output | 4 | Level device interrupt, one line per processor |

## Verification
A raw or pending bit held in the wrong state shows up first on the register port. The next read of the pending or raw register returns it one cycle after the request. If the stale bit is the only contributor, the processor's dev_irq line also shows it two edges after the stimulus. A mask that was corrupted, or that changed when it should not have, stays hidden until a source it covers is posted, or until the mask is read back. For that reason the bench reads every pending vector after each step and checks each dev_irq line at its exact edge. A lost error shows on err_flag in the cycle after the bad access, and it stays visible from then on.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int unsigned WORD_W    = 64;
    localparam int unsigned SLOT_BITS = 6;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PEND = 2'd2,
        SEL_RAW  = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned ADDR_W  = 12,
    localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int unsigned RIDX_W = ADDR_W - SLOT_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              aligned,
    output reg_kind_e         kind,
    output logic [CPU_W-1:0]  cpu_sel
);

    localparam int unsigned PEND_BASE = NUM_CPU;
    localparam int unsigned RAW_IDX   = 2 * NUM_CPU;

    logic [RIDX_W-1:0] ridx;
    logic [RIDX_W-1:0] off;

    always_comb begin
        ridx    = addr[ADDR_W-1:SLOT_BITS];
        aligned = (addr[SLOT_BITS-1:0] == '0);
        kind    = SEL_NONE;
        off     = ridx;
        if (int'(ridx) < NUM_CPU) begin
            kind = SEL_MASK;
        end else if (int'(ridx) < RAW_IDX) begin
            kind = SEL_PEND;
            off  = ridx - RIDX_W'(PEND_BASE);
        end else if (int'(ridx) == RAW_IDX) begin
            kind = SEL_RAW;
        end
        cpu_sel = off[CPU_W-1:0];
    end

endmodule

// File: rtl/irq_raw_vector.sv
module irq_raw_vector #(
    parameter int unsigned NUM_SRC = 64,
    localparam int unsigned SIDX_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_vld,
    input  logic [SIDX_W-1:0]  post_idx,
    input  logic               clr_vld,
    input  logic [SIDX_W-1:0]  clr_idx,
    output logic [NUM_SRC-1:0] raw_d,
    output logic [NUM_SRC-1:0] raw_q
);

    typedef struct packed {
        logic [NUM_SRC-1:0] raw;
    } raw_state_t;

    raw_state_t st_d, st_q;

    // clear first, then post: a post to the same source wins
    always_comb begin
        st_d = st_q;
        if (clr_vld) begin
            st_d.raw[clr_idx] = 1'b0;
        end
        if (post_vld) begin
            st_d.raw[post_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_d = st_d.raw;
    assign raw_q = st_q.raw;

endmodule

// File: rtl/irq_cpu_lane.sv
module irq_cpu_lane #(
    parameter int unsigned NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic [NUM_SRC-1:0] raw_nxt,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] pend_q,
    output logic               irq_q
);

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] pend;
        logic               irq;
    } lane_state_t;

    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
        // pending is derived from the next mask and the next raw vector
        st_d.pend = st_d.mask & raw_nxt;
        // the level line follows the registered pending vector one edge later
        st_d.irq  = |st_q.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;
    assign pend_q = st_q.pend;
    assign irq_q  = st_q.irq;

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned ADDR_W  = 12,
    localparam int unsigned SIDX_W = $clog2(NUM_SRC),
    localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                post_vld,
    input  logic [SIDX_W-1:0]   post_idx,
    input  logic                clr_vld,
    input  logic [SIDX_W-1:0]   clr_idx,
    input  logic                reg_vld,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [1:0]          reg_size,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic                rd_valid,
    output logic [WORD_W-1:0]   rd_data,
    output logic                err_flag,
    output logic [NUM_CPU-1:0]  dev_irq
);

    typedef struct packed {
        logic              rvalid;
        logic [WORD_W-1:0] rdata;
        logic              err;
    } port_state_t;

    port_state_t ps_d, ps_q;

    logic                            aligned;
    reg_kind_e                       kind;
    logic [CPU_W-1:0]                cpu_sel;
    logic                            acc_ok;
    logic                            wr_legal;
    logic                            acc_bad;
    logic [NUM_CPU-1:0]              mask_we;
    logic [NUM_SRC-1:0]              raw_d;
    logic [NUM_SRC-1:0]              raw_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_all;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] pend_all;

    irq_reg_decode #(
        .NUM_CPU (NUM_CPU),
        .ADDR_W  (ADDR_W)
    ) u_dec (
        .addr    (reg_addr),
        .aligned (aligned),
        .kind    (kind),
        .cpu_sel (cpu_sel)
    );

    irq_raw_vector #(
        .NUM_SRC (NUM_SRC)
    ) u_raw (
        .clk      (clk),
        .rst_n    (rst_n),
        .post_vld (post_vld),
        .post_idx (post_idx),
        .clr_vld  (clr_vld),
        .clr_idx  (clr_idx),
        .raw_d    (raw_d),
        .raw_q    (raw_q)
    );

    // access legality and write steering
    always_comb begin
        acc_ok   = (reg_size == SZ_DWORD) && aligned;
        wr_legal = reg_vld && reg_wr && acc_ok && (kind == SEL_MASK);
        acc_bad  = reg_vld && (!acc_ok || (reg_wr && (kind != SEL_MASK)));
        for (int c = 0; c < NUM_CPU; c++) begin
            mask_we[c] = wr_legal && (int'(cpu_sel) == c);
        end
    end

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_lane
        irq_cpu_lane #(
            .NUM_SRC (NUM_SRC)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .mask_we    (mask_we[g]),
            .mask_wdata (reg_wdata[NUM_SRC-1:0]),
            .raw_nxt    (raw_d),
            .mask_q     (mask_all[g]),
            .pend_q     (pend_all[g]),
            .irq_q      (dev_irq[g])
        );
    end

    // read return and sticky error
    always_comb begin
        ps_d        = ps_q;
        ps_d.rvalid = reg_vld && !reg_wr;
        ps_d.rdata  = '0;
        if (reg_vld && !reg_wr && acc_ok) begin
            unique case (kind)
                SEL_MASK: ps_d.rdata[NUM_SRC-1:0] = mask_all[cpu_sel];
                SEL_PEND: ps_d.rdata[NUM_SRC-1:0] = pend_all[cpu_sel];
                SEL_RAW:  ps_d.rdata[NUM_SRC-1:0] = raw_q;
                default:  ps_d.rdata              = '0;
            endcase
        end
        ps_d.err = ps_q.err || acc_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign rd_valid = ps_q.rvalid;
    assign rd_data  = ps_q.rdata;
    assign err_flag = ps_q.err;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned NUM_SRC = 64,
    localparam int unsigned SIDX_W = $clog2(NUM_SRC)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            post_vld,
    input logic [SIDX_W-1:0]               post_idx,
    input logic                            clr_vld,
    input logic [SIDX_W-1:0]               clr_idx,
    input logic                            reg_vld,
    input logic [1:0]                      reg_size,
    input logic                            err_flag,
    input logic [NUM_CPU-1:0]              dev_irq,
    input logic [NUM_SRC-1:0]              raw_q,
    input logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_all,
    input logic [NUM_CPU-1:0][NUM_SRC-1:0] pend_all
);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        // R1
        pend_is_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pend_all[c] == (mask_all[c] & raw_q));

        // R6
        irq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dev_irq[c] == $past(|pend_all[c]));
    end

    // R2
    post_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_vld |=> raw_q[$past(post_idx)]);

    // R3
    clear_drops_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && !(post_vld && post_idx == clr_idx)) |=> !raw_q[$past(clr_idx)]);

    // R4
    post_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vld && clr_vld && post_idx == clr_idx) |=> raw_q[$past(post_idx)]);

    // R8
    bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_vld && reg_size != 2'd3) |=> err_flag);

    // R8
    bad_size_masks_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_vld && reg_size != 2'd3) |=> $stable(mask_all));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

endmodule

bind irq_router irq_router_chk #(
    .NUM_CPU (NUM_CPU),
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .post_vld (post_vld),
    .post_idx (post_idx),
    .clr_vld  (clr_vld),
    .clr_idx  (clr_idx),
    .reg_vld  (reg_vld),
    .reg_size (reg_size),
    .err_flag (err_flag),
    .dev_irq  (dev_irq),
    .raw_q    (raw_q),
    .mask_all (mask_all),
    .pend_all (pend_all)
);

// File: tb/irq_router_test.sv
module irq_router_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 4;

    typedef struct packed {
        logic [1:0]  op;    // 0 post, 1 clear, 2 mask write
        logic [5:0]  arg;   // source number or processor
        logic [63:0] data;
    } step_t;

    localparam int NSTEP = 12;
    localparam step_t STEPS [NSTEP] = '{
        '{2'd2, 6'd0, 64'h0000_0000_0000_00F0},
        '{2'd0, 6'd4, 64'h0},
        '{2'd0, 6'd63, 64'h0},
        '{2'd2, 6'd1, 64'h8000_0000_0000_0000},
        '{2'd2, 6'd2, 64'hFFFF_FFFF_FFFF_FFFF},
        '{2'd1, 6'd4, 64'h0},
        '{2'd0, 6'd0, 64'h0},
        '{2'd2, 6'd3, 64'h0000_0000_0000_0001},
        '{2'd2, 6'd2, 64'h0},
        '{2'd1, 6'd63, 64'h0},
        '{2'd1, 6'd0, 64'h0},
        '{2'd0, 6'd5, 64'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_vld = 1'b0;
    logic [5:0]  post_idx = '0;
    logic        clr_vld = 1'b0;
    logic [5:0]  clr_idx = '0;
    logic        reg_vld = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [1:0]  reg_size = 2'd3;
    logic [63:0] reg_wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        err_flag;
    logic [3:0]  dev_irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] m_raw;
    logic [63:0] m_mask [NCPU];

    irq_router uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .post_vld  (post_vld),
        .post_idx  (post_idx),
        .clr_vld   (clr_vld),
        .clr_idx   (clr_idx),
        .reg_vld   (reg_vld),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_size  (reg_size),
        .reg_wdata (reg_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .err_flag  (err_flag),
        .dev_irq   (dev_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_raw = '0;
        for (int c = 0; c < NCPU; c++) m_mask[c] = '0;
    endtask

    // one cycle carrying any mix of post, clear and register write
    task automatic drive(input logic pv, input logic [5:0] pi, input logic cv, input logic [5:0] ci,
                         input logic wv, input logic [11:0] a, input logic [63:0] d, input logic [1:0] sz);
        post_vld = pv; post_idx = pi;
        clr_vld = cv;  clr_idx = ci;
        reg_vld = wv;  reg_wr = wv; reg_addr = a; reg_wdata = d; reg_size = sz;
        @(negedge clk);
        post_vld = 1'b0; clr_vld = 1'b0; reg_vld = 1'b0; reg_wr = 1'b0; reg_size = 2'd3;
    endtask

    task automatic do_read(input logic [11:0] a, input logic [1:0] sz, output logic [63:0] d, output logic v);
        reg_vld = 1'b1; reg_wr = 1'b0; reg_addr = a; reg_size = sz;
        @(negedge clk);
        reg_vld = 1'b0; reg_size = 2'd3;
        d = rd_data;
        v = rd_valid;
    endtask

    function automatic logic [3:0] model_irq();
        logic [3:0] r;
        for (int c = 0; c < NCPU; c++) r[c] = |(m_mask[c] & m_raw);
        return r;
    endfunction

    initial begin
        logic [63:0] d;
        logic        v;

        do_reset();

        // R12 reset state
        check("R12 dev_irq", {60'h0, dev_irq}, 64'h0);
        check("R12 err_flag", {63'h0, err_flag}, 64'h0);
        check("R12 rd_valid", {63'h0, rd_valid}, 64'h0);
        do_read(12'h200, 2'd3, d, v);
        check("R12 raw", d, 64'h0);
        do_read(12'h040, 2'd3, d, v);
        check("R12 mask1", d, 64'h0);

        // table walk: R1 R2 R3 R5 R6
        for (int i = 0; i < NSTEP; i++) begin
            case (STEPS[i].op)
                2'd0: begin
                    drive(1'b1, STEPS[i].arg, 1'b0, 6'd0, 1'b0, 12'h0, 64'h0, 2'd3);
                    m_raw[STEPS[i].arg] = 1'b1;
                end
                2'd1: begin
                    drive(1'b0, 6'd0, 1'b1, STEPS[i].arg, 1'b0, 12'h0, 64'h0, 2'd3);
                    m_raw[STEPS[i].arg] = 1'b0;
                end
                default: begin
                    drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, {STEPS[i].arg, 6'd0}, STEPS[i].data, 2'd3);
                    m_mask[STEPS[i].arg[1:0]] = STEPS[i].data;
                end
            endcase
            do_read(12'h200, 2'd3, d, v);
            check("R2 raw vector", d, m_raw);
            for (int c = 0; c < NCPU; c++) begin
                do_read(12'h100 + 12'(c * 64), 2'd3, d, v);
                check("R1 pending vector", d, m_mask[c] & m_raw);
                do_read(12'(c * 64), 2'd3, d, v);
                check("R5 mask readback", d, m_mask[c]);
            end
            check("R6 dev_irq level", {60'h0, dev_irq}, {60'h0, model_irq()});
        end

        // R6 exact edge
        do_reset();
        drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 12'h040, 64'h0000_0000_0000_0400, 2'd3);
        drive(1'b1, 6'd10, 1'b0, 6'd0, 1'b0, 12'h0, 64'h0, 2'd3);
        check("R6 irq not yet risen", {63'h0, dev_irq[1]}, 64'h0);
        @(negedge clk);
        check("R6 irq risen", {60'h0, dev_irq}, 64'h2);
        drive(1'b0, 6'd0, 1'b1, 6'd10, 1'b0, 12'h0, 64'h0, 2'd3);
        check("R6 irq not yet fallen", {63'h0, dev_irq[1]}, 64'h1);
        @(negedge clk);
        check("R6 irq fallen", {60'h0, dev_irq}, 64'h0);

        // R3 spurious clear
        drive(1'b1, 6'd7, 1'b0, 6'd0, 1'b0, 12'h0, 64'h0, 2'd3);
        drive(1'b0, 6'd0, 1'b1, 6'd20, 1'b0, 12'h0, 64'h0, 2'd3);
        @(negedge clk);
        check("R3 spurious clear keeps irq", {60'h0, dev_irq}, 64'h0);
        do_read(12'h200, 2'd3, d, v);
        check("R3 spurious clear keeps raw", d, 64'h80);

        // R4 same-cycle post and clear
        drive(1'b1, 6'd9, 1'b1, 6'd9, 1'b0, 12'h0, 64'h0, 2'd3);
        do_read(12'h200, 2'd3, d, v);
        check("R4 same source post wins", d, 64'h280);
        drive(1'b1, 6'd11, 1'b1, 6'd7, 1'b0, 12'h0, 64'h0, 2'd3);
        do_read(12'h200, 2'd3, d, v);
        check("R4 different sources both apply", d, 64'hA00);

        // R11 mask write with post in the same cycle
        drive(1'b1, 6'd12, 1'b0, 6'd0, 1'b1, 12'h000, 64'h0000_0000_0000_1200, 2'd3);
        do_read(12'h100, 2'd3, d, v);
        check("R11 pending uses new mask and raw", d, 64'h1200);

        // R7 read handshake and unmapped read
        do_read(12'h300, 2'd3, d, v);
        check("R7 unmapped reads zero", d, 64'h0);
        check("R7 rd_valid on read", {63'h0, v}, 64'h1);
        drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 12'h0C0, 64'h0, 2'd3);
        check("R7 no rd_valid on write", {63'h0, rd_valid}, 64'h0);
        check("R7 legal write no error", {63'h0, err_flag}, 64'h0);

        // R9 unsupported writes
        drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 12'h100, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3);
        check("R9 pending write error", {63'h0, err_flag}, 64'h1);
        do_read(12'h100, 2'd3, d, v);
        check("R9 pending unchanged", d, 64'h1200);
        drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 12'h200, 64'h0, 2'd3);
        do_read(12'h200, 2'd3, d, v);
        check("R9 raw unchanged", d, 64'h1A00);

        // R10 sticky
        drive(1'b1, 6'd1, 1'b0, 6'd0, 1'b0, 12'h0, 64'h0, 2'd3);
        do_read(12'h000, 2'd3, d, v);
        check("R10 error stays set", {63'h0, err_flag}, 64'h1);

        // R12 reset clears error, R8 bad size and misalignment
        do_reset();
        check("R12 error cleared by reset", {63'h0, err_flag}, 64'h0);
        drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 12'h000, 64'hFF, 2'd3);
        do_read(12'h000, 2'd2, d, v);
        check("R8 bad size read returns zero", d, 64'h0);
        check("R8 bad size sets error", {63'h0, err_flag}, 64'h1);
        drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 12'h000, 64'h55, 2'd1);
        drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 12'h008, 64'h66, 2'd3);
        do_read(12'h000, 2'd3, d, v);
        check("R8 illegal writes leave mask", d, 64'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule